// File: doc/BRIEF.md
# Bigram Word-Entry Score Propagator

After the per-state update of a decoding frame, every word whose final state survived has to hand its score on to the words that may follow it. This block takes one finished word at a time: its final-state score, a precomputed best bigram score, and the location and length of its list of successors. It adds the best bigram score to the word score and compares the sum with the language-model threshold. A word that fails this test is dropped without reading a single list entry. A word that passes has its whole successor list streamed from an external synchronous list memory, one entry per cycle.

Each list entry is handled by a two-stage pipeline. The first stage forms the candidate score (word score plus the entry's bigram score) and tests it against the threshold. A surviving candidate reads the successor's current entry score from a dual-port score memory. The second stage keeps the larger of the two by writing the candidate back only when it wins. When two entries in a row hit the same successor, the value just written is forwarded in place of the stale read. The caller marks the final word of a batch, and the block pulses `done` once nothing of that batch is left in flight.

Top module: `word_link_prop`

## Requirements
- R1: A word is accepted when `word_valid` and `word_ready` are both high at a clock edge. If the saturated sum `word_score + word_best` is not strictly greater than `thresh`, the word issues no list read and changes no entry score.
- R2: An accepted word whose sum passes R1 and whose `word_count` is N > 0 issues exactly N list reads. They go to addresses `word_base` up to `word_base + N - 1` on consecutive cycles, starting the cycle after acceptance. A word with `word_count` zero issues none.
- R3: Each list word carries the bigram score in bits [SW+EW-1:EW] and the successor index in bits [EW-1:0]. Data returns one cycle after the read. The candidate is the saturated sum of the word score and the bigram score. Only a candidate strictly greater than `thresh` reads the entry memory, and it does so at the successor index in the cycle the list data is present.
- R4: An entry score returns one cycle after its read. The candidate is written to the same index in that cycle only if it is strictly greater than the stored score, so the write comes two cycles after the list read.
- R5: When an entry follows, in the very next cycle, an entry that wrote the same successor, it compares against the value just written and not against the memory read. The memory may return the old value on a read that collides with a write.
- R6: All additions saturate to the signed SW-bit range: results above 2^(SW-1)-1 clamp to that maximum, and results below -2^(SW-1) clamp to that minimum.
- R7: After a word flagged with `word_last` is accepted, `done` is high for exactly one cycle. That cycle is the first in which no list read of the batch is outstanding and both pipeline stages are empty, so it is the cycle after the last write when the final entry writes.
- R8: During and right after reset, no memory read or write is issued, `done` is low and `word_ready` is high.
- R9: `word_ready` is low in every cycle in which a list read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | SW | Language-model threshold, signed |
| word_valid | input | 1 | A finished word is offered |
| word_ready | output | 1 | Block can accept a word |
| word_score | input | SW | Final-state score of the word, signed |
| word_best | input | SW | Best bigram score of the word's list, signed |
| word_base | input | LAW | First list address of the word |
| word_count | input | CW | Number of list entries |
| word_last | input | 1 | Word closes the batch |
| lst_rd_en | output | 1 | List memory read strobe |
| lst_rd_addr | output | LAW | List memory read address |
| lst_rd_data | input | SW+EW | List word, one cycle after the read |
| ent_rd_en | output | 1 | Entry-score read strobe |
| ent_rd_addr | output | EW | Entry-score read index |
| ent_rd_data | input | SW | Entry score, one cycle after the read |
| ent_wr_en | output | 1 | Entry-score write strobe |
| ent_wr_addr | output | EW | Entry-score write index |
| ent_wr_data | output | SW | Entry score written |
| done | output | 1 | One-cycle batch completion pulse |

## Verification
The bench models the entry memory as read-old-on-collision. Back-to-back entries aimed at one successor then expose a design without forwarding: it would write a smaller second candidate over the first. Candidates equal to the threshold or to the stored score must produce neither a read nor a write, which catches a non-strict comparison. Sums pushed past both ends of the range would wrap to the wrong sign without saturation, and a failing best score on the last word must still end in a single `done` pulse with no list traffic. The issue-to-read-to-write spacing and the pulse position after the last write are measured in cycles, so an added or missing register shows up as a wrong offset.

// File: rtl/word_link_prop.sv
module word_link_prop #(
  parameter int SW  = 16,
  parameter int EW  = 8,
  parameter int LAW = 10,
  parameter int CW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] thresh,
  input  logic                 word_valid,
  output logic                 word_ready,
  input  logic signed [SW-1:0] word_score,
  input  logic signed [SW-1:0] word_best,
  input  logic [LAW-1:0]       word_base,
  input  logic [CW-1:0]        word_count,
  input  logic                 word_last,
  output logic                 lst_rd_en,
  output logic [LAW-1:0]       lst_rd_addr,
  input  logic [SW+EW-1:0]     lst_rd_data,
  output logic                 ent_rd_en,
  output logic [EW-1:0]        ent_rd_addr,
  input  logic signed [SW-1:0] ent_rd_data,
  output logic                 ent_wr_en,
  output logic [EW-1:0]        ent_wr_addr,
  output logic signed [SW-1:0] ent_wr_data,
  output logic                 done
);

  localparam logic signed [SW-1:0] MAXV = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {1'b1, {(SW-1){1'b0}}};

  function automatic logic signed [SW-1:0] sat_add(input logic signed [SW-1:0] a,
                                                   input logic signed [SW-1:0] b);
    logic signed [SW:0] s;
    s = {a[SW-1], a} + {b[SW-1], b};
    if (s[SW] != s[SW-1]) return s[SW] ? MINV : MAXV;
    return s[SW-1:0];
  endfunction

  logic                 busy, last_q, drain;
  logic [LAW-1:0]       ptr;
  logic [CW-1:0]        remain;
  logic signed [SW-1:0] score_q;

  logic                 s1_v, s2_v, fw_v;
  logic [EW-1:0]        s2_addr, fw_addr;
  logic signed [SW-1:0] s2_cand, fw_data;

  wire                  accept = word_valid && word_ready;
  wire signed [SW-1:0]  pre_sum = sat_add(word_score, word_best);
  wire                  pre_ok = (pre_sum > thresh) && (word_count != '0);
  wire                  issue_end = busy && (remain == CW'(1));

  assign word_ready  = !busy;
  assign lst_rd_en   = busy;
  assign lst_rd_addr = ptr;

  wire signed [SW-1:0]  lm_s = lst_rd_data[SW+EW-1:EW];
  wire [EW-1:0]         tgt  = lst_rd_data[EW-1:0];
  wire signed [SW-1:0]  cand = sat_add(score_q, lm_s);
  wire                  s1_pass = s1_v && (cand > thresh);

  assign ent_rd_en   = s1_pass;
  assign ent_rd_addr = tgt;

  wire signed [SW-1:0]  cur = (fw_v && fw_addr == s2_addr) ? fw_data : ent_rd_data;

  assign ent_wr_en   = s2_v && (s2_cand > cur);
  assign ent_wr_addr = s2_addr;
  assign ent_wr_data = s2_cand;

  assign done = drain && !busy && !s1_v && !s2_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      last_q  <= 1'b0;
      ptr     <= '0;
      remain  <= '0;
      score_q <= '0;
    end else if (busy) begin
      ptr    <= ptr + LAW'(1);
      remain <= remain - CW'(1);
      if (issue_end) busy <= 1'b0;
    end else if (accept && pre_ok) begin
      busy    <= 1'b1;
      ptr     <= word_base;
      remain  <= word_count;
      score_q <= word_score;
      last_q  <= word_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drain <= 1'b0;
    else if (done) drain <= 1'b0;
    else if ((issue_end && last_q) || (accept && !pre_ok && word_last)) drain <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      s2_addr <= '0;
      s2_cand <= '0;
      fw_v    <= 1'b0;
      fw_addr <= '0;
      fw_data <= '0;
    end else begin
      s1_v    <= busy;
      s2_v    <= s1_pass;
      s2_addr <= tgt;
      s2_cand <= cand;
      fw_v    <= ent_wr_en;
      fw_addr <= ent_wr_addr;
      fw_data <= ent_wr_data;
    end
  end

  assert_skip_no_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pre_ok) |=> !lst_rd_en);

  assert_list_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lst_rd_en && !issue_end) |=> (lst_rd_en && lst_rd_addr == $past(lst_rd_addr) + LAW'(1)));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr_en |-> ($past(ent_rd_en) && ent_wr_addr == $past(ent_rd_addr)));

  assert_write_above_thresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr_en |-> (ent_wr_data > thresh));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_low_on_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lst_rd_en |-> !word_ready);

endmodule

// File: tb/word_link_prop_test.sv
`timescale 1ns/1ps
module word_link_prop_test;
  localparam int SW = 16, EW = 8, LAW = 10, CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic signed [SW-1:0] thresh = '0;
  logic word_valid = 1'b0, word_ready, word_last = 1'b0;
  logic signed [SW-1:0] word_score = '0, word_best = '0;
  logic [LAW-1:0] word_base = '0;
  logic [CW-1:0]  word_count = '0;
  logic lst_rd_en, ent_rd_en, ent_wr_en, done;
  logic [LAW-1:0] lst_rd_addr;
  logic [SW+EW-1:0] lst_rd_data;
  logic [EW-1:0] ent_rd_addr, ent_wr_addr;
  logic signed [SW-1:0] ent_rd_data, ent_wr_data;

  word_link_prop #(.SW(SW), .EW(EW), .LAW(LAW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .word_valid(word_valid), .word_ready(word_ready),
    .word_score(word_score), .word_best(word_best),
    .word_base(word_base), .word_count(word_count), .word_last(word_last),
    .lst_rd_en(lst_rd_en), .lst_rd_addr(lst_rd_addr), .lst_rd_data(lst_rd_data),
    .ent_rd_en(ent_rd_en), .ent_rd_addr(ent_rd_addr), .ent_rd_data(ent_rd_data),
    .ent_wr_en(ent_wr_en), .ent_wr_addr(ent_wr_addr), .ent_wr_data(ent_wr_data),
    .done(done));

  logic [SW+EW-1:0]     lst_mem [0:1023];
  logic signed [SW-1:0] ent_mem [0:255];
  logic signed [SW-1:0] model   [0:255];

  always @(posedge clk) begin
    lst_rd_data <= lst_rd_en ? lst_mem[lst_rd_addr] : '0;
    if (ent_rd_en) ent_rd_data <= ent_mem[ent_rd_addr];
    if (ent_wr_en) ent_mem[ent_wr_addr] <= ent_wr_data;
  end

  int checks = 0, errors = 0;
  int cyc = 0, n_lst = 0, n_erd = 0, n_wr = 0, n_done = 0, dbl = 0, rdy_bad = 0;
  int lst_cyc = 0, erd_cyc = 0, wr_cyc = 0, done_cyc = 0;
  logic done_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (lst_rd_en) begin n_lst++; lst_cyc = cyc; if (word_ready) rdy_bad++; end
    if (ent_rd_en) begin n_erd++; erd_cyc = cyc; end
    if (ent_wr_en) begin n_wr++; wr_cyc = cyc; end
    if (done) begin n_done++; done_cyc = cyc; if (done_prev) dbl++; end
    done_prev = done;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic clear_counts();
    n_lst = 0; n_erd = 0; n_wr = 0; n_done = 0; dbl = 0;
  endtask

  task automatic fill_ent(input int v);
    for (int i = 0; i < 256; i++) begin ent_mem[i] = v; model[i] = v; end
  endtask

  task automatic put(input int a, input int lm, input int t);
    lst_mem[a] = {16'(lm), 8'(t)};
  endtask

  task automatic send(input int sc, input int bst, input int base, input int cnt, input bit last);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1'b1; word_score = 16'(sc); word_best = 16'(bst);
    word_base = 10'(base); word_count = 6'(cnt); word_last = last;
    @(negedge clk);
    word_valid = 1'b0; word_last = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (n_done == 0 && k < 500) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    chk(n_done == 1 && dbl == 0, tag, n_done, 1);
  endtask

  task automatic model_word(input int sc, input int bst, input int base, input int cnt);
    if (sat(sc + bst) > int'(thresh) && cnt > 0)
      for (int i = 0; i < cnt; i++) begin
        int lm = int'($signed(lst_mem[base + i][23:8]));
        int t  = int'(lst_mem[base + i][7:0]);
        int c  = sat(sc + lm);
        if (c > int'(thresh) && c > int'(model[t])) model[t] = 16'(c);
      end
  endtask

  localparam int NW = 6;
  localparam int T_SC  [NW] = '{-50, -300, -100, -190, 10, -20};
  localparam int T_BST [NW] = '{-10, -5, -20, -5, 0, -5};
  localparam int T_BASE[NW] = '{0, 8, 16, 28, 40, 44};
  localparam int T_CNT [NW] = '{8, 8, 12, 8, 0, 10};
  localparam bit T_LAST[NW] = '{0, 0, 0, 0, 0, 1};

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual %0d expected 0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) lst_mem[i] = '0;
    fill_ent(-1000);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!lst_rd_en && !ent_rd_en && !ent_wr_en, "R8 no access in reset", int'(lst_rd_en), 0);
    chk(!done && word_ready, "R8 done low ready high", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!lst_rd_en && !ent_wr_en && !done && word_ready, "R8 idle after reset", int'(done), 0);

    // Table walk: R1 R2 R3 R4 R5 together against the sequential model
    thresh = -200;
    for (int a = 0; a < 64; a++) put(a, -((a * 7) % 50) - 5 + ((a % 3) * 20), (a / 2) % 13);
    fill_ent(-1000);
    clear_counts();
    for (int w = 0; w < NW; w++) begin
      model_word(T_SC[w], T_BST[w], T_BASE[w], T_CNT[w]);
      send(T_SC[w], T_BST[w], T_BASE[w], T_CNT[w], T_LAST[w]);
    end
    wait_done("R7 table done pulse");
    chk(n_lst == 38, "R2 table list read count", n_lst, 38);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (ent_mem[i] != model[i]) bad++;
      chk(bad == 0, "R4 table entry scores", bad, 0);
    end

    // R1: last word fails pre-check
    thresh = -200; fill_ent(-1000); clear_counts();
    for (int a = 100; a < 105; a++) put(a, 0, 3);
    send(-300, 50, 100, 5, 1'b1);
    wait_done("R7 done after skipped last word");
    chk(n_lst == 0, "R1 skipped word list reads", n_lst, 0);
    chk(ent_mem[3] == -1000, "R1 skipped word entry", int'(ent_mem[3]), -1000);

    // R5: back-to-back entries to one successor
    thresh = -500; fill_ent(-1000); clear_counts();
    put(200, 30, 5); put(201, 10, 5); put(202, 20, 5);
    send(100, 30, 200, 3, 1'b1);
    wait_done("R7 forward case done");
    chk(ent_mem[5] == 130, "R5 forwarded max", int'(ent_mem[5]), 130);
    chk(n_wr == 1, "R5 single write", n_wr, 1);

    // R4 R7: timing of one entry
    thresh = -500; fill_ent(-1000); clear_counts();
    put(300, 0, 7);
    send(50, 0, 300, 1, 1'b1);
    wait_done("R7 single entry done");
    chk(erd_cyc == lst_cyc + 1, "R3 entry read one cycle after list read", erd_cyc - lst_cyc, 1);
    chk(wr_cyc == lst_cyc + 2, "R4 write two cycles after list read", wr_cyc - lst_cyc, 2);
    chk(done_cyc == wr_cyc + 1, "R7 done cycle after last write", done_cyc - wr_cyc, 1);
    chk(ent_mem[7] == 50, "R4 written value", int'(ent_mem[7]), 50);

    // R3 R4: strict comparisons
    thresh = 0; fill_ent(-1000); clear_counts();
    ent_mem[10] = 60;
    put(400, -50, 9); put(401, 10, 10); put(402, 20, 11);
    send(50, 20, 400, 3, 1'b1);
    wait_done("R7 strict case done");
    chk(n_erd == 2, "R3 equal-threshold candidate not read", n_erd, 2);
    chk(n_wr == 1 && ent_mem[10] == 60, "R4 equal score not written", int'(ent_mem[10]), 60);
    chk(ent_mem[11] == 70 && ent_mem[9] == -1000, "R3 passing candidate written", int'(ent_mem[11]), 70);

    // R2: zero-count word
    thresh = -500; fill_ent(-1000); clear_counts();
    send(0, 0, 500, 0, 1'b1);
    wait_done("R7 zero count done");
    chk(n_lst == 0, "R2 zero count no reads", n_lst, 0);

    // R6: saturation both ways
    thresh = -32768; fill_ent(-1000); clear_counts();
    put(600, 32000, 12); put(601, -32000, 13);
    send(32000, 32000, 600, 1, 1'b0);
    send(-32000, 0, 601, 1, 1'b1);
    wait_done("R7 saturation done");
    chk(ent_mem[12] == 32767, "R6 positive clamp", int'(ent_mem[12]), 32767);
    chk(ent_mem[13] == -1000, "R6 negative clamp not above threshold", int'(ent_mem[13]), -1000);

    chk(rdy_bad == 0, "R9 ready low during list reads", rdy_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule